// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Unit

This block sits beside a free-running timer and turns its single-cycle event strobes into sticky status flags. Five compare-match strobes, four capture-edge strobes, an overflow strobe, a real-time tick and two pulse-accumulator strobes arrive as one-cycle pulses. Each strobe sets a flag that stays set until software clears it by writing a one to that flag's position. Each flag has an enable bit in a matching mask register. The block raises one registered interrupt request whenever any flag and its enable are both one.

Software reaches four byte-wide registers through a simple address, write-enable and data port. Two of them form a primary flag/mask pair for the compare and capture channels. The other two form a secondary pair for overflow, real-time and pulse-accumulator events. The secondary mask register also holds a two-bit prescaler select, which the block drives out to the timer. One position of the primary pair is shared between capture 4 and compare 5, and a mode input chooses which of the two it serves.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset, every mask and flag bit, the prescaler select and `irq_o` are zero.
- R2: The register map is 0x22 primary mask (read/write), 0x23 primary flags, 0x24 secondary mask, 0x25 secondary flags. Any other address reads 0x00.
- R3: A one-cycle strobe sets its flag at the next clock edge. Primary flag bit order, from bit 7 to bit 0: OC1, OC2, OC3, OC4, shared channel, IC1, IC2, IC3. Inputs `oc_evt_i[k]` and `ic_evt_i[k]` carry channel k+1.
- R4: A flag clears only when a write to its register carries a one in its position. Zero bits in the write leave flags unchanged.
- R5: If a strobe and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R6: When `cap4_sel_i` is 1, bit 3 is set by IC4 and OC5 is ignored. When it is 0, bit 3 is set by OC5 and IC4 is ignored.
- R7: Secondary mask bits 7..4 enable overflow, real-time, pulse-accumulator overflow and pulse-accumulator input. These flags sit at the same bit positions of 0x25. Mask bits 1..0 drive `prescale_o`.
- R8: Secondary mask bits 3..2 and secondary flag bits 3..0 always read zero and ignore writes.
- R9: `irq_o` is the OR of all flag-and-enable pairs, registered, so it changes one clock edge after the flags or masks change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational from addr_i) |
| oc_evt_i | input | 5 | Compare-match strobes, bit k is OC(k+1) |
| ic_evt_i | input | 4 | Capture-edge strobes, bit k is IC(k+1) |
| cap4_sel_i | input | 1 | 1: shared bit is capture 4; 0: compare 5 |
| tof_evt_i | input | 1 | Timer overflow strobe |
| rti_evt_i | input | 1 | Real-time tick strobe |
| paov_evt_i | input | 1 | Pulse-accumulator overflow strobe |
| pai_evt_i | input | 1 | Pulse-accumulator input-edge strobe |
| prescale_o | output | 2 | Prescaler select from secondary mask bits 1..0 |
| irq_o | output | 1 | Registered interrupt request |

## Verification
On every cycle, the assertions check four things. Each strobe, routed through the shared-bit select, leaves its flag set. No flag falls without a write-one to that position. A set that collides with a clear wins. `irq_o` equals the previous cycle's OR of enabled flags. They also hold the unused secondary mask bits at zero. Only the bench scenarios can show the address decode, the exact bit order seen by software, the reset read-back and the prescaler output.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned AW      = 8;
  localparam int unsigned NUM_OC  = 5;
  localparam int unsigned NUM_IC  = 4;
  localparam int unsigned NUM_AUX = 4;
  localparam logic [AW-1:0] ADDR_MSK1 = 8'h22;
  localparam logic [AW-1:0] ADDR_FLG1 = 8'h23;
  localparam logic [AW-1:0] ADDR_MSK2 = 8'h24;
  localparam logic [AW-1:0] ADDR_FLG2 = 8'h25;
  // writable bits of secondary mask: enables [7:4], prescale [1:0]
  localparam logic [DW-1:0] MSK2_WMASK = 8'hF3;
  localparam int unsigned   PRE_W      = 2;
endpackage

// File: rtl/tmr_evt_map.sv
module tmr_evt_map
  import tmr_irq_pkg::*;
#(
  parameter int unsigned N_OC = NUM_OC,
  parameter int unsigned N_IC = NUM_IC
) (
  input  logic [N_OC-1:0] oc_evt_i,
  input  logic [N_IC-1:0] ic_evt_i,
  input  logic            cap4_sel_i,
  output logic [DW-1:0]   set_o
);
  localparam int unsigned DED_OC = N_OC - 1;   // compare channels with own bit
  localparam int unsigned DED_IC = N_IC - 1;   // capture channels with own bit
  localparam int unsigned SHR    = DED_IC;     // shared bit position

  for (genvar i = 0; i < DED_OC; i++) begin : g_oc
    assign set_o[DW-1-i] = oc_evt_i[i];
  end
  for (genvar i = 0; i < DED_IC; i++) begin : g_ic
    assign set_o[DED_IC-1-i] = ic_evt_i[i];
  end
  assign set_o[SHR] = cap4_sel_i ? ic_evt_i[N_IC-1] : oc_evt_i[N_OC-1];
endmodule

// File: rtl/tmr_w1c_bank.sv
module tmr_w1c_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  // set has priority so a colliding event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | set_i;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
  import tmr_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NUM_OC-1:0] oc_evt_i,
  input  logic [NUM_IC-1:0] ic_evt_i,
  input  logic              cap4_sel_i,
  input  logic              tof_evt_i,
  input  logic              rti_evt_i,
  input  logic              paov_evt_i,
  input  logic              pai_evt_i,
  output logic [PRE_W-1:0]  prescale_o,
  output logic              irq_o
);
  localparam int unsigned AUX_LO = DW - NUM_AUX;

  logic [DW-1:0]      mask1_q, mask2_q, flag1_q, set1;
  logic [NUM_AUX-1:0] flag2_q, set2, clr2;
  logic [DW-1:0]      clr1;
  logic               wr_msk1, wr_flg1, wr_msk2, wr_flg2;
  logic               irq_q;

  assign wr_msk1 = we_i && (addr_i == ADDR_MSK1);
  assign wr_flg1 = we_i && (addr_i == ADDR_FLG1);
  assign wr_msk2 = we_i && (addr_i == ADDR_MSK2);
  assign wr_flg2 = we_i && (addr_i == ADDR_FLG2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask1_q <= '0;
      mask2_q <= '0;
    end else begin
      if (wr_msk1) mask1_q <= wdata_i;
      if (wr_msk2) mask2_q <= wdata_i & MSK2_WMASK;
    end
  end

  tmr_evt_map #(.N_OC(NUM_OC), .N_IC(NUM_IC)) u_map (
    .oc_evt_i   (oc_evt_i),
    .ic_evt_i   (ic_evt_i),
    .cap4_sel_i (cap4_sel_i),
    .set_o      (set1)
  );

  assign clr1 = wr_flg1 ? wdata_i : '0;
  assign set2 = {tof_evt_i, rti_evt_i, paov_evt_i, pai_evt_i};
  assign clr2 = wr_flg2 ? wdata_i[DW-1:AUX_LO] : '0;

  tmr_w1c_bank #(.W(DW)) u_flg1 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set1),
    .clr_i  (clr1),
    .flag_o (flag1_q)
  );

  tmr_w1c_bank #(.W(NUM_AUX)) u_flg2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set2),
    .clr_i  (clr2),
    .flag_o (flag2_q)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_MSK1: rdata_o = mask1_q;
      ADDR_FLG1: rdata_o = flag1_q;
      ADDR_MSK2: rdata_o = mask2_q;
      ADDR_FLG2: rdata_o = {flag2_q, {AUX_LO{1'b0}}};
      default:   rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (|(flag1_q & mask1_q)) | (|(flag2_q & mask2_q[DW-1:AUX_LO]));
  end

  assign irq_o      = irq_q;
  assign prescale_o = mask2_q[PRE_W-1:0];
endmodule

// File: rtl/tmr_irq_chk.sv
module tmr_irq_chk
  import tmr_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AW-1:0]     addr_i,
  input logic              we_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic [NUM_OC-1:0] oc_evt_i,
  input logic [NUM_IC-1:0] ic_evt_i,
  input logic              cap4_sel_i,
  input logic              tof_evt_i,
  input logic              rti_evt_i,
  input logic              paov_evt_i,
  input logic              pai_evt_i,
  input logic              irq_o,
  input logic [DW-1:0]     mask1_q,
  input logic [DW-1:0]     mask2_q,
  input logic [DW-1:0]     flag1_q,
  input logic [NUM_AUX-1:0] flag2_q
);
  logic          vld_q;
  logic [DW-1:0] ev1, cl1;
  logic [NUM_AUX-1:0] ev2, cl2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= 1'b1;
  end

  assign ev1 = {oc_evt_i[0], oc_evt_i[1], oc_evt_i[2], oc_evt_i[3],
                (cap4_sel_i ? ic_evt_i[3] : oc_evt_i[4]),
                ic_evt_i[0], ic_evt_i[1], ic_evt_i[2]};
  assign cl1 = (we_i && addr_i == ADDR_FLG1) ? wdata_i : 8'h00;
  assign ev2 = {tof_evt_i, rti_evt_i, paov_evt_i, pai_evt_i};
  assign cl2 = (we_i && addr_i == ADDR_FLG2) ? wdata_i[7:4] : 4'h0;

  assert_evt_sets_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> ((flag1_q & $past(ev1)) == $past(ev1)));

  assert_fall_needs_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> ((($past(flag1_q) & ~flag1_q) & ~$past(cl1)) == 8'h00));

  assert_aux_fall_needs_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> ((($past(flag2_q) & ~flag2_q) & ~$past(cl2)) == 4'h0));

  assert_set_beats_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> ((flag2_q & $past(ev2 & cl2)) == $past(ev2 & cl2)));

  assert_unused_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_MSK2) |-> (rdata_o[3:2] == 2'b00));

  assert_irq_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (irq_o == $past((|(flag1_q & mask1_q)) | (|(flag2_q & mask2_q[7:4])))));
endmodule

bind tmr_irq_unit tmr_irq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .oc_evt_i   (oc_evt_i),
  .ic_evt_i   (ic_evt_i),
  .cap4_sel_i (cap4_sel_i),
  .tof_evt_i  (tof_evt_i),
  .rti_evt_i  (rti_evt_i),
  .paov_evt_i (paov_evt_i),
  .pai_evt_i  (pai_evt_i),
  .irq_o      (irq_o),
  .mask1_q    (mask1_q),
  .mask2_q    (mask2_q),
  .flag1_q    (flag1_q),
  .flag2_q    (flag2_q)
);

// File: tb/tmr_irq_unit_tb.sv
`timescale 1ns/1ps
module tmr_irq_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [4:0] oc = '0;
  logic [3:0] ic = '0;
  logic       sel = 1'b0;
  logic       tof = 1'b0, rti = 1'b0, paov = 1'b0, pai = 1'b0;
  logic [1:0] pre;
  logic       irq;
  int         n_chk = 0;
  int         n_fail = 0;
  logic [7:0] r;

  always #4 clk = ~clk;

  tmr_irq_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .oc_evt_i(oc), .ic_evt_i(ic), .cap4_sel_i(sel),
    .tof_evt_i(tof), .rti_evt_i(rti), .paov_evt_i(paov), .pai_evt_i(pai),
    .prescale_o(pre), .irq_o(irq)
  );

  // {oc[4:0], ic[3:0], sel, expected primary flags}
  localparam logic [17:0] VEC [9] = '{
    {5'b00001, 4'b0000, 1'b0, 8'h80},  // OC1
    {5'b01000, 4'b0000, 1'b0, 8'h10},  // OC4
    {5'b10000, 4'b0000, 1'b0, 8'h08},  // OC5 in compare mode
    {5'b10000, 4'b0000, 1'b1, 8'h00},  // OC5 ignored in capture mode
    {5'b00000, 4'b1000, 1'b1, 8'h08},  // IC4 in capture mode
    {5'b00000, 4'b1000, 1'b0, 8'h00},  // IC4 ignored in compare mode
    {5'b00000, 4'b0001, 1'b0, 8'h04},  // IC1
    {5'b00000, 4'b0100, 1'b0, 8'h01},  // IC3
    {5'b00110, 4'b0010, 1'b0, 8'h62}   // OC2, OC3, IC2
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    addr = a; we = 1'b0; #1; d = rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(8'h22, r); chk("R1 mask1", r, 8'h00);
    rd(8'h23, r); chk("R1 flag1", r, 8'h00);
    rd(8'h24, r); chk("R1 mask2", r, 8'h00);
    rd(8'h25, r); chk("R1 flag2", r, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    tick();
    rd(8'h23, r); chk("R1 flag1 after release", r, 8'h00);
    chk("R1 prescale", {6'd0, pre}, 8'h00);

    // R3 R6 vector walk
    foreach (VEC[i]) begin
      sel = VEC[i][8];
      oc  = VEC[i][17:13];
      ic  = VEC[i][12:9];
      tick();
      oc = '0; ic = '0;
      rd(8'h23, r);
      chk((i inside {[2:5]}) ? "R6 shared bit" : "R3 event bit", r, VEC[i][7:0]);
      wr(8'h23, 8'hFF);
    end
    sel = 1'b0;

    // R2 register map
    wr(8'h22, 8'hA5);
    rd(8'h22, r); chk("R2 mask1 readback", r, 8'hA5);
    rd(8'h26, r); chk("R2 unmapped", r, 8'h00);
    wr(8'h22, 8'h00);

    // R4 write-one-to-clear
    oc = 5'b00001; ic = 4'b0100; tick(); oc = '0; ic = '0;
    wr(8'h23, 8'h01); rd(8'h23, r); chk("R4 clear one bit", r, 8'h80);
    wr(8'h23, 8'h00); rd(8'h23, r); chk("R4 zero write no effect", r, 8'h80);
    wr(8'h23, 8'h80); rd(8'h23, r); chk("R4 clear last", r, 8'h00);

    // R5 set beats clear
    oc = 5'b00001; wr(8'h23, 8'h80); oc = '0;
    rd(8'h23, r); chk("R5 set wins", r, 8'h80);
    wr(8'h23, 8'hFF);

    // R7 R8 secondary pair
    wr(8'h24, 8'hFF);
    rd(8'h24, r); chk("R8 mask2 unused bits", r, 8'hF3);
    chk("R7 prescale", {6'd0, pre}, 8'h03);
    tof = 1'b1; pai = 1'b1; tick(); tof = 1'b0; pai = 1'b0;
    rd(8'h25, r); chk("R7 flag2 positions", r, 8'h90);
    wr(8'h25, 8'h0F); rd(8'h25, r); chk("R8 flag2 low bits ignored", r, 8'h90);
    wr(8'h25, 8'h80); rd(8'h25, r); chk("R4 flag2 clear", r, 8'h10);
    rti = 1'b1; paov = 1'b1; wr(8'h25, 8'h20); rti = 1'b0; paov = 1'b0;
    rd(8'h25, r); chk("R5 flag2 set wins", r, 8'h70);
    wr(8'h25, 8'h60);

    // R9 registered irq
    chk("R9 irq from flag2", {7'd0, irq}, 8'h01);
    wr(8'h24, 8'h00);
    chk("R9 irq held one cycle", {7'd0, irq}, 8'h01);
    tick();
    chk("R9 irq drops", {7'd0, irq}, 8'h00);
    wr(8'h25, 8'hF0);
    oc = 5'b00010; tick(); oc = '0;
    tick();
    chk("R9 masked flag no irq", {7'd0, irq}, 8'h00);
    wr(8'h22, 8'h40);
    chk("R9 irq not yet", {7'd0, irq}, 8'h00);
    tick();
    chk("R9 irq rises", {7'd0, irq}, 8'h01);

    finish_run();
  end
endmodule